// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block is a first-level data translation buffer. It maps a virtual address to a physical address in a single combinational lookup. It keeps three separate associative arrays, one for each page size: 4 KiB, 2 MiB and 1 GiB. All three are searched at the same time. The size of the matching page sets how many low address bits pass through unchanged.

When a lookup misses, no translation is returned. The requester must obtain the translation elsewhere and install it through the fill port. The fill port carries a page size code, a virtual address inside the page and the physical base of the page. The array for that size picks a way for the new entry, taking an invalid way before evicting a valid one, and uses a 4-way tree pseudo-LRU policy otherwise. A flush input invalidates every entry at once.

Top module: `dtlb_multi_size`

## Requirements
- R1: The 4 KiB array has 16 sets of 4 ways, and the set is chosen by vaddr[15:12]. Four pages that share a set are all held. A fifth page in that set leaves exactly four of the five resident.
- R2: The 2 MiB array has 8 sets of 4 ways, and the set is chosen by vaddr[23:21]. Five pages filled into one set leave exactly four resident.
- R3: The 1 GiB array is fully associative with 4 entries. Five distinct pages leave exactly four resident, and the most recent one is always among them.
- R4: The lookup is combinational. hit_o, paddr_o and size_o reflect vaddr_i in the same cycle that lookup_valid_i is high. While lookup_valid_i is low, hit_o is 0. A fill becomes visible from the cycle after it is presented.
- R5: On a hit, paddr_o is the stored physical page joined to the untranslated offset. The offset is vaddr_i[11:0], [20:0] or [29:0] for size codes 0 (4 KiB), 1 (2 MiB) and 2 (1 GiB). size_o gives that code, and code 3 is never output.
- R6: On a miss, hit_o is 0 and both paddr_o and size_o are 0.
- R7: When several arrays hit, the smallest page size is returned.
- R8: A fill into a set that has an invalid way takes the lowest-numbered invalid way. Filling four pages into an empty set therefore keeps all four.
- R9: Each set keeps a 3-bit tree pseudo-LRU state. The state is cleared at reset and refreshed by every lookup hit and every fill. In a full set, the victim is the way the tree points away from. After fills of A, B, C, D in that order and then a hit on A, the next fill evicts C.
- R10: A fill whose virtual page is already present in its array overwrites that entry in place. Later lookups return the new physical page.
- R11: flush_i invalidates every entry of all arrays in one cycle. A fill presented in the same cycle as a flush is dropped.
- R12: After reset every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lookup_valid_i | input | 1 | Lookup request |
| vaddr_i | input | VA_W | Virtual address to translate |
| fill_valid_i | input | 1 | Install a translation |
| fill_size_i | input | 2 | Page size code of the fill (0 4K, 1 2M, 2 1G) |
| fill_vaddr_i | input | VA_W | Any virtual address inside the filled page |
| fill_pbase_i | input | PA_W | Physical base of the page; offset bits ignored |
| hit_o | output | 1 | Translation found |
| paddr_o | output | PA_W | Translated physical address |
| size_o | output | 2 | Page size code of the matched entry |

## Verification
The hardest state to reach from the ports is a full set whose pseudo-LRU tree points at a chosen way. The only way to steer the tree is through the order of fills and hits. The bench fills four 4 KiB pages that share vaddr[15:12], then issues a hit on the oldest one, and computes from the tree rule that the next fill must displace the third page. Priority between arrays is exercised by placing a 4 KiB page inside a resident 1 GiB page and looking up addresses on both sides of it.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int NUM_SIZES = 3;
  localparam int TLB_WAYS  = 4;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  function automatic int off_bits(int g);
    return (g == 0) ? 12 : (g == 1) ? 21 : 30;
  endfunction
endpackage

// File: rtl/dtlb_set_array.sv
module dtlb_set_array #(
  parameter int SETS  = 16,
  parameter int VPN_W = 36,
  parameter int PPN_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lk_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i
);
  localparam int WAYS  = dtlb_pkg::TLB_WAYS;
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

  logic [WAYS-1:0]  vld_q  [SETS];
  logic [2:0]       plru_q [SETS];
  logic [VPN_W-1:0] vpn_q  [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q  [SETS][WAYS];

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [WAYS-1:0]  lk_match, fl_match;
  logic [1:0]       lk_way, fl_way;

  assign lk_set = (SETS > 1) ? lk_vpn_i[IDX_W-1:0]   : '0;
  assign fl_set = (SETS > 1) ? fill_vpn_i[IDX_W-1:0] : '0;

  // tree: bit0 picks half, bit1 left pair, bit2 right pair; touch points away
  function automatic logic [2:0] plru_touch(logic [2:0] s, logic [1:0] w);
    logic [2:0] n;
    n    = s;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

  function automatic logic [1:0] plru_victim(logic [2:0] s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction

  always_comb begin
    ppn_o  = '0;
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld_q[lk_set][w] && (vpn_q[lk_set][w] == lk_vpn_i);
      if (lk_match[w]) begin
        ppn_o  = ppn_o | ppn_q[lk_set][w];
        lk_way = 2'(w);
      end
    end
    hit_o = lk_i && (|lk_match);
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      fl_match[w] = vld_q[fl_set][w] && (vpn_q[fl_set][w] == fill_vpn_i);
    fl_way = plru_victim(plru_q[fl_set]);
    if (|fl_match) begin
      for (int w = 0; w < WAYS; w++)
        if (fl_match[w]) fl_way = 2'(w);
    end else if (!(&vld_q[fl_set])) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!vld_q[fl_set][w]) fl_way = 2'(w);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (hit_o) plru_q[lk_set] <= plru_touch(plru_q[lk_set], lk_way);
      if (fill_i) begin
        vld_q[fl_set][fl_way] <= 1'b1;
        plru_q[fl_set]        <= plru_touch(plru_q[fl_set], fl_way);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !flush_i) begin
      vpn_q[fl_set][fl_way] <= fill_vpn_i;
      ppn_q[fl_set][fl_way] <= fill_ppn_i;
    end
  end
endmodule

// File: rtl/dtlb_multi_size.sv
module dtlb_multi_size #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int SETS_4K = 16,
  parameter int SETS_2M = 8,
  parameter int SETS_1G = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            lookup_valid_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            fill_valid_i,
  input  logic [1:0]      fill_size_i,
  input  logic [VA_W-1:0] fill_vaddr_i,
  input  logic [PA_W-1:0] fill_pbase_i,
  output logic            hit_o,
  output logic [PA_W-1:0] paddr_o,
  output logic [1:0]      size_o
);
  import dtlb_pkg::*;

  logic [NUM_SIZES-1:0] hit_g;
  logic [PA_W-1:0]      pa_g [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_arr
    localparam int OFF  = off_bits(g);
    localparam int SETS = (g == 0) ? SETS_4K : (g == 1) ? SETS_2M : SETS_1G;
    logic [PA_W-OFF-1:0] ppn;

    dtlb_set_array #(
      .SETS (SETS),
      .VPN_W(VA_W - OFF),
      .PPN_W(PA_W - OFF)
    ) i_arr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .lk_i      (lookup_valid_i),
      .lk_vpn_i  (vaddr_i[VA_W-1:OFF]),
      .hit_o     (hit_g[g]),
      .ppn_o     (ppn),
      .fill_i    (fill_valid_i && (fill_size_i == 2'(g)) && !flush_i),
      .fill_vpn_i(fill_vaddr_i[VA_W-1:OFF]),
      .fill_ppn_i(fill_pbase_i[PA_W-1:OFF])
    );

    assign pa_g[g] = {ppn, vaddr_i[OFF-1:0]};
  end

  // descending walk: smallest page size assigned last, so it wins
  always_comb begin
    hit_o   = 1'b0;
    paddr_o = '0;
    size_o  = PG_4K;
    for (int g = NUM_SIZES - 1; g >= 0; g--) begin
      if (hit_g[g]) begin
        hit_o   = 1'b1;
        paddr_o = pa_g[g];
        size_o  = 2'(g);
      end
    end
  end
endmodule

// File: rtl/dtlb_multi_size_chk.sv
module dtlb_multi_size_chk #(
  parameter int VA_W = 48,
  parameter int PA_W = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flush_i,
  input logic            lookup_valid_i,
  input logic [VA_W-1:0] vaddr_i,
  input logic            fill_valid_i,
  input logic [VA_W-1:0] fill_vaddr_i,
  input logic            hit_o,
  input logic [PA_W-1:0] paddr_o,
  input logic [1:0]      size_o
);
  assert_idle_no_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> !hit_o);

  assert_fill_visible_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) |=>
      (!lookup_valid_i || (vaddr_i != $past(fill_vaddr_i)) || hit_o));

  assert_offset_passthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (paddr_o[11:0] == vaddr_i[11:0]));

  assert_size_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (size_o != 2'd3));

  assert_miss_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (paddr_o == '0 && size_o == 2'd0));

  assert_flush_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);
endmodule

bind dtlb_multi_size dtlb_multi_size_chk #(.VA_W(VA_W), .PA_W(PA_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .lookup_valid_i(lookup_valid_i),
  .vaddr_i       (vaddr_i),
  .fill_valid_i  (fill_valid_i),
  .fill_vaddr_i  (fill_vaddr_i),
  .hit_o         (hit_o),
  .paddr_o       (paddr_o),
  .size_o        (size_o)
);

// File: tb/test_dtlb_multi_size.sv
module test_dtlb_multi_size;
  localparam int VA_W = 48;
  localparam int PA_W = 40;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            flush_i = 1'b0;
  logic            lookup_valid_i = 1'b0;
  logic [VA_W-1:0] vaddr_i = '0;
  logic            fill_valid_i = 1'b0;
  logic [1:0]      fill_size_i = '0;
  logic [VA_W-1:0] fill_vaddr_i = '0;
  logic [PA_W-1:0] fill_pbase_i = '0;
  logic            hit_o;
  logic [PA_W-1:0] paddr_o;
  logic [1:0]      size_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtlb_multi_size #(.VA_W(VA_W), .PA_W(PA_W)) i_dtlb_multi_size (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .lookup_valid_i(lookup_valid_i), .vaddr_i(vaddr_i),
    .fill_valid_i(fill_valid_i), .fill_size_i(fill_size_i),
    .fill_vaddr_i(fill_vaddr_i), .fill_pbase_i(fill_pbase_i),
    .hit_o(hit_o), .paddr_o(paddr_o), .size_o(size_o)
  );

  typedef struct packed {
    logic            lk;
    logic [1:0]      sz;
    logic [VA_W-1:0] va;
    logic [PA_W-1:0] pb;
    logic            ehit;
    logic [PA_W-1:0] epa;
    logic [1:0]      esz;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd0, 48'h0000_1234_5000, 40'h12_3456_7000, 1'b0, 40'h0, 2'd0},
    '{1'b0, 2'd1, 48'h0000_4040_0000, 40'h00_8020_0000, 1'b0, 40'h0, 2'd0},
    '{1'b0, 2'd2, 48'h0080_0000_0000, 40'h40_C000_0000, 1'b0, 40'h0, 2'd0},
    '{1'b0, 2'd0, 48'h0080_0000_3000, 40'h00_0007_7000, 1'b0, 40'h0, 2'd0},
    '{1'b1, 2'd0, 48'h0000_1234_5ABC, 40'h0, 1'b1, 40'h12_3456_7ABC, 2'd0}, // R5 4K
    '{1'b1, 2'd0, 48'h0000_405F_FFF0, 40'h0, 1'b1, 40'h00_803F_FFF0, 2'd1}, // R5 2M
    '{1'b1, 2'd0, 48'h0080_3FFF_FFFF, 40'h0, 1'b1, 40'h40_FFFF_FFFF, 2'd2}, // R5 1G
    '{1'b1, 2'd0, 48'h0000_1234_6000, 40'h0, 1'b0, 40'h0, 2'd0},            // R6 miss
    '{1'b1, 2'd0, 48'h0080_0000_3010, 40'h0, 1'b1, 40'h00_0007_7010, 2'd0}, // R7 4K beats 1G
    '{1'b1, 2'd0, 48'h0080_0000_4010, 40'h0, 1'b1, 40'h40_C000_4010, 2'd2}  // R7 1G only
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic do_fill(logic [1:0] sz, logic [VA_W-1:0] va, logic [PA_W-1:0] pb);
    fill_valid_i = 1'b1; fill_size_i = sz; fill_vaddr_i = va; fill_pbase_i = pb;
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  logic            s_hit;
  logic [PA_W-1:0] s_pa;
  logic [1:0]      s_sz;

  task automatic do_lookup(logic [VA_W-1:0] va);
    lookup_valid_i = 1'b1; vaddr_i = va;
    #5;
    s_hit = hit_o; s_pa = paddr_o; s_sz = size_o;
    @(negedge clk);
    lookup_valid_i = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12: empty after reset
    do_lookup(48'h0000_1234_5000);
    chk("R12 hit after reset", 64'(s_hit), 64'd0);
    chk("R6 pa on miss", 64'(s_pa), 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (!TBL[i].lk) begin
        do_fill(TBL[i].sz, TBL[i].va, TBL[i].pb);
      end else begin
        do_lookup(TBL[i].va);
        chk($sformatf("R5/R7 row %0d hit", i), 64'(s_hit), 64'(TBL[i].ehit));
        chk($sformatf("R5/R7 row %0d paddr", i), 64'(s_pa), 64'(TBL[i].epa));
        chk($sformatf("R5/R7 row %0d size", i), 64'(s_sz), 64'(TBL[i].esz));
      end
    end

    // R4: request low means no hit even for a resident page
    vaddr_i = 48'h0000_1234_5ABC; lookup_valid_i = 1'b0;
    #5;
    chk("R4 idle hit", 64'(hit_o), 64'd0);
    @(negedge clk);

    // R11: flush clears everything
    flush_i = 1'b1; @(negedge clk); flush_i = 1'b0;
    do_lookup(48'h0000_1234_5ABC);
    chk("R11 4K after flush", 64'(s_hit), 64'd0);
    do_lookup(48'h0080_3FFF_FFFF);
    chk("R11 1G after flush", 64'(s_hit), 64'd0);
    flush_i = 1'b1;
    do_fill(2'd0, 48'h0000_0000_9000, 40'h00_0001_1000);
    flush_i = 1'b0;
    do_lookup(48'h0000_0000_9000);
    chk("R11 fill dropped under flush", 64'(s_hit), 64'd0);

    // R1/R8: four 4K pages in set 7 all held
    for (int k = 1; k <= 4; k++)
      do_fill(2'd0, 48'(k) << 16 | 48'h7000, 40'(k) << 12);
    cnt = 0;
    for (int k = 1; k <= 4; k++) begin
      do_lookup(48'(k) << 16 | 48'h7000);
      cnt += int'(s_hit);
    end
    chk("R8 four fills in empty set held", 64'(cnt), 64'd4);
    // R9: hit on A, then fill E must evict C (way 2)
    do_lookup(48'h0001_7000);
    do_fill(2'd0, 48'h0005_7000, 40'h5000);
    do_lookup(48'h0003_7000);
    chk("R9 C evicted", 64'(s_hit), 64'd0);
    do_lookup(48'h0001_7000);
    chk("R9 A kept", 64'(s_hit), 64'd1);
    cnt = 0;
    for (int k = 1; k <= 5; k++) begin
      do_lookup(48'(k) << 16 | 48'h7000);
      cnt += int'(s_hit);
    end
    chk("R1 set capacity", 64'(cnt), 64'd4);

    // R2: five 2M pages in set 3
    for (int k = 1; k <= 5; k++)
      do_fill(2'd1, (48'(k) << 24) | 48'h60_0000, 40'(k) << 21);
    cnt = 0;
    for (int k = 1; k <= 5; k++) begin
      do_lookup((48'(k) << 24) | 48'h60_0000);
      cnt += int'(s_hit);
    end
    chk("R2 2M set capacity", 64'(cnt), 64'd4);

    // R3: five 1G pages, fully associative
    for (int k = 1; k <= 5; k++)
      do_fill(2'd2, 48'(k) << 30, 40'(k + 8) << 30);
    do_lookup(48'(5) << 30 | 48'h123);
    chk("R3 newest 1G resident", 64'(s_pa), (64'(13) << 30) | 64'h123);
    cnt = 0;
    for (int k = 1; k <= 5; k++) begin
      do_lookup(48'(k) << 30);
      cnt += int'(s_hit);
    end
    chk("R3 1G capacity", 64'(cnt), 64'd4);

    // R10: refill replaces the physical page in place
    do_fill(2'd0, 48'h0001_7000, 40'hAB_CDE0_0000);
    do_lookup(48'h0001_7044);
    chk("R10 refill paddr", 64'(s_pa), 64'hAB_CDE0_0044);
    cnt = 0;
    for (int k = 1; k <= 5; k++) begin
      do_lookup(48'(k) << 16 | 48'h7000);
      cnt += int'(s_hit);
    end
    chk("R10 no duplicate eviction", 64'(cnt), 64'd4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule